// File: doc/BRIEF.md
# Mantissa-Exponent Digital Gain Stage

This block scales a stream of complex baseband samples by a programmable gain. The gain is a floating-point-like word: a 4-bit shift exponent N and a 14-bit fraction X with an implied leading one. The linear gain is 2^N × (1 + X/16384). That covers from unity up to about 96.3 dB using one multiplier per rail and a barrel shifter.

Each valid I/Q pair is captured together with the gain word presented in the same cycle, so both rails always see the same gain. The product is shifted left by N, rounded half-up back to the sample's fractional weight, and clamped to the output range. The scaled pair appears two clock cycles after it was accepted. A loop controller outside this block is expected to compute the gain word.

Top module: `mant_exp_gain`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_i and out_q are 0.
- R2: The gain word is gain[17:14] = N (shift exponent, 0..15) and gain[13:0] = X (unsigned fraction). Each accepted sample s produces round(s × 2^N × (16384 + X) / 16384), where samples are signed two's complement integers of the output width.
- R3: A result above 32767 gives 32767, and a result below -32768 gives -32768. A result never wraps to the opposite sign.
- R4: Rounding is half-up on the 14 discarded fraction bits, so an exact .5 rounds toward plus infinity: 1.5 gives 2 and -1.5 gives -1.
- R5: out_valid is in_valid delayed by exactly two clock cycles, and back-to-back valid samples are accepted every cycle.
- R6: A gain word of all zeros reproduces the input sample exactly on both rails.
- R7: On cycles where in_valid is low, in_i, in_q and gain are ignored. out_i and out_q hold the last produced result until the next valid result.
- R8: I and Q are scaled by the same gain word, which is taken from the cycle in which the pair is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair qualifier |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| gain | input | 18 | {exponent[3:0], fraction[13:0]} |
| out_valid | output | 1 | Output pair qualifier |
| out_i | output | 16 | Scaled in-phase sample |
| out_q | output | 16 | Scaled quadrature sample |

## Verification
The hardest case to reach from the ports is an exact half-way point in the discarded bits. With random stimulus it almost never occurs. The bench produces it on purpose with a fraction of 8192 (a gain of 1.5) applied to odd samples of both signs, so the round-half-up rule shows up as 2 versus -1. Saturation edges are reached with full-scale samples at the largest exponents. Idle cycles carry changing data and gain to show that nothing leaks into the held outputs.

// File: rtl/mant_exp_gain.sv
module mant_exp_gain #(
  parameter int DW = 16,
  parameter int MW = 14,
  parameter int EW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_i,
  input  logic [DW-1:0]        in_q,
  input  logic [EW+MW-1:0]     gain,
  output logic                 out_valid,
  output logic [DW-1:0]        out_i,
  output logic [DW-1:0]        out_q
);
  localparam int PW = DW + MW + 2;
  localparam int SW = PW + (1 << EW) - 1;
  localparam logic signed [SW-1:0] ONE  = 1;
  localparam logic signed [SW-1:0] OMAX = (ONE <<< (DW-1)) - ONE;
  localparam logic signed [SW-1:0] OMIN = -(ONE <<< (DW-1));
  localparam logic signed [SW-1:0] HALF = ONE <<< (MW-1);

  logic signed [MW+1:0] mult;
  logic signed [PW-1:0] p_i, p_q;
  logic [EW-1:0]        e1;
  logic                 v1;

  assign mult = $signed({2'b01, gain[MW-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      e1  <= '0;
      p_i <= '0;
      p_q <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        p_i <= $signed(in_i) * mult;
        p_q <= $signed(in_q) * mult;
        e1  <= gain[EW+MW-1:MW];
      end
    end
  end

  function automatic logic [DW-1:0] shape(input logic signed [PW-1:0] p,
                                          input logic [EW-1:0] e);
    logic signed [SW-1:0] s;
    s = SW'(p);
    s = (s <<< e) + HALF;
    s = s >>> MW;
    if (s > OMAX)      s = OMAX;
    else if (s < OMIN) s = OMIN;
    return s[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_i <= shape(p_i, e1);
        out_q <= shape(p_q, e1);
      end
    end
  end

  a_r5_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid);
  a_r5_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> ($stable(out_i) && $stable(out_q)));
  a_r3_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !p_i[PW-1]) |=> !out_i[DW-1]);
  a_r3_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && p_q[PW-1]) |=> (out_q[DW-1] || out_q == '0));
  a_r6_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == '0) |-> ##2 (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));
endmodule

// File: tb/tb_mant_exp_gain.sv
module tb_mant_exp_gain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic [17:0] gain = '0;
  logic out_valid;
  logic [15:0] out_i, out_q;

  int errors = 0, checks = 0;
  logic hv[2];
  longint hi[2], hq[2];
  string htag[2];
  longint li = 0, lq = 0;

  always #2.5 clk = ~clk;

  mant_exp_gain dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i),
    .in_q(in_q), .gain(gain), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  function automatic longint model(longint x, int m, int n);
    longint s;
    s = x * (16384 + m);
    s = s <<< n;
    s = (s + 8192) >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic v, int x, int y, int n, int m, string tag);
    @(negedge clk);
    if (hv[1]) begin li = hi[1]; lq = hq[1]; end
    chk({htag[1], " R5 valid"}, longint'(out_valid), longint'(hv[1]));
    chk({htag[1], " I"}, longint'($signed(out_i)), li);
    chk({htag[1], " Q"}, longint'($signed(out_q)), lq);
    hv[1] = hv[0]; hi[1] = hi[0]; hq[1] = hq[0]; htag[1] = htag[0];
    hv[0] = v;
    hi[0] = model(longint'(x), m, n);
    hq[0] = model(longint'(y), m, n);
    htag[0] = tag;
    in_valid = v;
    in_i = x[15:0];
    in_q = y[15:0];
    gain = {n[3:0], m[13:0]};
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    hv[0] = 0; hv[1] = 0; hi[0] = 0; hi[1] = 0; hq[0] = 0; hq[1] = 0;
    htag[0] = "R1"; htag[1] = "R1";
    repeat (3) begin
      @(negedge clk);
      chk("R1 valid", longint'(out_valid), 0);
      chk("R1 I", longint'(out_i), 0);
      chk("R1 Q", longint'(out_q), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1, 1234, -4321, 0, 0, "R6");
    step(1, 32767, -32768, 0, 0, "R6");
    step(1, -1, 1, 0, 0, "R6");
    step(1, 0, 0, 0, 0, "R6");
    step(1, 1000, -1000, 1, 0, "R2");
    step(1, 100, 200, 3, 4096, "R2");
    step(1, -77, 55, 7, 16383, "R8");
    step(1, 3, -3, 15, 0, "R2");
    step(1, 1, -1, 0, 8192, "R4");
    step(1, -1, 1, 0, 8192, "R4");
    step(1, 3, -3, 0, 8192, "R4");
    step(1, 5, -5, 1, 2048, "R4");
    step(1, 32767, -32768, 15, 16383, "R3");
    step(1, -32768, 32767, 1, 0, "R3");
    step(1, 20000, -20000, 0, 10000, "R3");
    step(1, 16384, -16384, 1, 0, "R3");
    step(0, 9999, -9999, 15, 16383, "R7");
    step(0, -5, 5, 3, 77, "R7");
    step(0, 123, 321, 9, 1, "R7");
    step(1, 50, -60, 2, 300, "R5");
    step(0, 7, 7, 4, 4, "R7");
    step(1, -60, 50, 2, 300, "R5");
    for (int k = 0; k < 2000; k++) begin
      int x, y, n, m;
      logic v;
      v = ($urandom % 4) != 0;
      x = $signed(16'($urandom));
      y = $signed(16'($urandom));
      n = $urandom % 16;
      m = $urandom % 16384;
      if (($urandom % 2) == 0) n = n % 3;
      step(v, x, y, n, m, v ? "R2" : "R7");
    end
    step(0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule